// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

The block runs on a fast input clock and turns it into a slower square wave. The low half and the high half of that wave are each programmed on their own. Each length is a 4-bit field that holds the number of input cycles minus one. A chip-level synchronization pulse puts the divider back to a known start level. After the pulse is released, a programmable offset of input cycles passes before the first phase begins. This lets several dividers that share one sync line line up their edges with a chosen skew.

Configuration arrives as register-style input fields, and the block samples them while it runs:

- A phase length is read at the moment that phase begins.
- The offset and the start level are read when the divider leaves its hold state.

Other modes:

- **Bypass** parks the counters and passes the input clock straight through.
- **Sync-ignore** detaches the divider from the sync pulse and turns the registered level into a static one. The force-high field selects whether that static level is high or low.

The block has two outputs. The first is the registered output level, which is suited to cycle-by-cycle checking. The second is a divided-clock signal that is gated by an enable input.

Top module: `clk_div_prog`

## Requirements
- R1: While rst_ni is low, lvl_o and div_clk_o are both 0.
- R2: When running, each low phase of lvl_o lasts cfg_lo_i+1 input cycles. cfg_lo_i is 0..15, so a field of 0 gives one cycle.
- R3: When running, each high phase of lvl_o lasts cfg_hi_i+1 input cycles. cfg_hi_i is 0..15.
- R4: The first phase after sync release or reset is the one at the start level: high when cfg_start_hi_i=1, low when it is 0. The sequence then alternates forever. Take E0 as the first rising edge at which sync is not obeyed. lvl_o keeps the start level up to the toggle at edge E0+P+N0+1, where N0 is the length field of the start level.
- R5: The phase offset cfg_phase_i (P, 0..15) delays the first toggle by exactly P input cycles compared with P=0.
- R6: Sync is obeyed when sync_i=1 and cfg_nosync_i=0. While it is obeyed, lvl_o is at the start level from the first edge that samples it.
- R7: When cfg_bypass_i=1, div_clk_o equals clk_i as long as en_i=1, and lvl_o is held at the start level.
- R8: When cfg_nosync_i=1 and bypass is off, lvl_o takes the static value cfg_force_hi_i one edge later, and sync_i has no effect on it.
- R9: When en_i=0, div_clk_o is 0. When en_i=1 and bypass is off, div_clk_o equals lvl_o.
- R10: A change to a length field during a phase does not alter that phase. The new value takes effect the next time a phase of that level begins.
- R11: With every field zero after reset, lvl_o divides by two: 0 after the first edge, then 1, 0, 1 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Gate for div_clk_o |
| sync_i | input | 1 | Chip-level synchronization, active high |
| cfg_lo_i | input | 4 | Low phase length minus one |
| cfg_hi_i | input | 4 | High phase length minus one |
| cfg_phase_i | input | 4 | Offset in input cycles after sync release |
| cfg_start_hi_i | input | 1 | Start level: 1 high, 0 low |
| cfg_bypass_i | input | 1 | Route the input clock to div_clk_o, park the counters |
| cfg_nosync_i | input | 1 | Ignore sync_i; lvl_o becomes static |
| cfg_force_hi_i | input | 1 | Static level used when cfg_nosync_i=1 |
| lvl_o | output | 1 | Registered divider level |
| div_clk_o | output | 1 | Enable-gated divided clock, or the input clock in bypass |

## Verification
The assertions assume that configuration inputs and sync_i change only between clock edges, never on one. They do not assume that the fields stay fixed during a run: each property compares the level with configuration values sampled one edge earlier. The stimulus changes every input one time unit after a rising edge. Length fields change during a run only in the reload test, and there the change is made partway through a phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } div_st_e;

  typedef struct packed {
    logic [3:0] lo;
    logic [3:0] hi;
    logic [3:0] phase;
    logic       start_hi;
    logic       bypass;
    logic       nosync;
    logic       force_hi;
  } div_cfg_t;
endpackage

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int PH_W  = 4,
  localparam int CNT_W = (LEN_W > PH_W) ? LEN_W : PH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  div_cfg_t         cfg_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_dec_o,
  output logic             lvl_o
);
  div_st_e st_q, st_d;
  logic    lvl_q, lvl_d;
  logic    sync_obey;

  assign sync_obey = sync_i && !cfg_i.nosync;

  function automatic logic [CNT_W-1:0] len_of(input logic lvl, input div_cfg_t c);
    return lvl ? CNT_W'(c.hi) : CNT_W'(c.lo);
  endfunction

  always_comb begin
    st_d       = st_q;
    lvl_d      = lvl_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    cnt_dec_o  = 1'b0;
    if (cfg_i.bypass) begin
      st_d  = ST_HOLD;
      lvl_d = cfg_i.start_hi;
    end else if (cfg_i.nosync) begin
      st_d  = ST_HOLD;
      lvl_d = cfg_i.force_hi;
    end else if (sync_obey) begin
      st_d  = ST_HOLD;
      lvl_d = cfg_i.start_hi;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          lvl_d      = cfg_i.start_hi;
          cnt_load_o = 1'b1;
          if (cfg_i.phase == '0) begin
            st_d      = ST_RUN;
            cnt_val_o = len_of(cfg_i.start_hi, cfg_i);
          end else begin
            st_d      = ST_WAIT;
            cnt_val_o = CNT_W'(cfg_i.phase) - 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt_zero_i) begin
            st_d       = ST_RUN;
            cnt_load_o = 1'b1;
            cnt_val_o  = len_of(lvl_q, cfg_i);
          end else begin
            cnt_dec_o = 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt_zero_i) begin
            lvl_d      = !lvl_q;
            cnt_load_o = 1'b1;
            cnt_val_o  = len_of(!lvl_q, cfg_i);
          end else begin
            cnt_dec_o = 1'b1;
          end
        end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      lvl_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R6
  sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_obey && !cfg_i.bypass) |=> (lvl_q == $past(cfg_i.start_hi)));

  // R8
  static_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.nosync && !cfg_i.bypass) |=> (lvl_q == $past(cfg_i.force_hi)));

  // R7
  bypass_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.bypass |=> (lvl_q == $past(cfg_i.start_hi)));

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !cnt_zero_i && !cfg_i.bypass && !cfg_i.nosync && !sync_i)
      |=> $stable(lvl_q));

  // R5
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !cfg_i.bypass && !cfg_i.nosync && !sync_i) |=> $stable(lvl_q));
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out (
  input  logic clk_i,
  input  logic en_i,
  input  logic bypass_i,
  input  logic lvl_i,
  output logic div_clk_o
);
  logic src;
  assign src       = bypass_i ? clk_i : lvl_i;
  assign div_clk_o = en_i & src;
endmodule

// File: rtl/clk_div_prog.sv
module clk_div_prog
  import clkdiv_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int PH_W  = 4,
  localparam int CNT_W = (LEN_W > PH_W) ? LEN_W : PH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sync_i,
  input  logic [LEN_W-1:0] cfg_lo_i,
  input  logic [LEN_W-1:0] cfg_hi_i,
  input  logic [PH_W-1:0]  cfg_phase_i,
  input  logic             cfg_start_hi_i,
  input  logic             cfg_bypass_i,
  input  logic             cfg_nosync_i,
  input  logic             cfg_force_hi_i,
  output logic             lvl_o,
  output logic             div_clk_o
);
  div_cfg_t         cfg;
  logic             cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  always_comb begin
    cfg          = '0;
    cfg.lo       = 4'(cfg_lo_i);
    cfg.hi       = 4'(cfg_hi_i);
    cfg.phase    = 4'(cfg_phase_i);
    cfg.start_hi = cfg_start_hi_i;
    cfg.bypass   = cfg_bypass_i;
    cfg.nosync   = cfg_nosync_i;
    cfg.force_hi = cfg_force_hi_i;
  end

  clkdiv_ctrl #(.LEN_W(LEN_W), .PH_W(PH_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .cfg_i      (cfg),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cnt_dec_o  (cnt_dec),
    .lvl_o      (lvl_o)
  );

  clkdiv_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero)
  );

  clkdiv_out u_out (
    .clk_i     (clk_i),
    .en_i      (en_i),
    .bypass_i  (cfg_bypass_i),
    .lvl_i     (lvl_o),
    .div_clk_o (div_clk_o)
  );

  // R1
  rst_lvl_chk: assert property (@(posedge clk_i) !rst_ni |-> !lvl_o);
endmodule

// File: tb/sim_clk_div_prog.sv
`timescale 1ns/1ps
module sim_clk_div_prog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, sync = 1'b0;
  logic [3:0] lo = '0, hi = '0, ph = '0;
  logic st_hi = 1'b0, byp = 1'b0, nosync = 1'b0, force_hi = 1'b0;
  logic lvl, div_clk;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_div_prog u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sync_i(sync),
    .cfg_lo_i(lo), .cfg_hi_i(hi), .cfg_phase_i(ph),
    .cfg_start_hi_i(st_hi), .cfg_bypass_i(byp), .cfg_nosync_i(nosync),
    .cfg_force_hi_i(force_hi), .lvl_o(lvl), .div_clk_o(div_clk)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // expected level t edges after the release edge E0 (t=0 is E0 itself)
  function automatic logic exp_lvl(input int t, input int l, input int h,
                                   input logic s, input int p);
    int n0, n1, k, m;
    n0 = s ? h : l;
    n1 = s ? l : h;
    k  = t - p - n0 - 1;
    if (k < 0) return s;
    m = k % (n0 + n1 + 2);
    return (m < n1 + 1) ? !s : s;
  endfunction

  initial begin
    #2;
    chk(lvl, 1'b0, "R1 lvl in reset");
    chk(div_clk, 1'b0, "R1 div_clk in reset");
    #20 rst_n = 1'b1;  // next posedge at 28 is E0
    for (int t = 0; t < 12; t++) begin
      step();
      chk(lvl, exp_lvl(t, 0, 0, 1'b0, 0), "R11 default divide by two");
      chk(div_clk, lvl, "R9 div_clk follows lvl");
    end

    // sweep of lengths, start level and offset
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 4; h++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 4; p++) begin
            lo = 4'(l); hi = 4'(h); st_hi = s[0]; ph = 4'(p);
            sync = 1'b1;
            step();
            chk(lvl, s[0], "R6 held at start level");
            step();
            chk(lvl, s[0], "R6 held at start level");
            sync = 1'b0;
            for (int t = 0; t < 30; t++) begin
              step();
              chk(lvl, exp_lvl(t, l, h, s[0], p), "R2 R3 R4 R5 waveform");
            end
          end

    // one wide field value
    lo = 4'd15; hi = 4'd1; st_hi = 1'b0; ph = 4'd9;
    sync = 1'b1; step(); sync = 1'b0;
    for (int t = 0; t < 60; t++) begin
      step();
      chk(lvl, exp_lvl(t, 15, 1, 1'b0, 9), "R2 R5 wide fields");
    end

    // reload at phase start: lo changed during high phase
    lo = 4'd0; hi = 4'd3; ph = 4'd0; st_hi = 1'b0;
    sync = 1'b1; step(); sync = 1'b0;
    step(); step(); step();  // edges t=0,1,2
    lo = 4'd2;
    step(); step();          // t=3,4
    chk(lvl, 1'b1, "R10 current high phase unchanged");
    step(); chk(lvl, 1'b0, "R10 new low phase t5");
    step(); chk(lvl, 1'b0, "R10 new low phase t6");
    step(); chk(lvl, 1'b0, "R10 new low phase t7");
    step(); chk(lvl, 1'b1, "R10 high after new low phase");

    // bypass
    byp = 1'b1; st_hi = 1'b1; en = 1'b1;
    step(); step();
    chk(lvl, 1'b1, "R7 lvl at start level");
    chk(div_clk, 1'b1, "R7 div_clk with clk high");
    #4;
    chk(div_clk, 1'b0, "R7 div_clk with clk low");
    step();
    en = 1'b0; #1;
    chk(div_clk, 1'b0, "R9 gated in bypass");
    st_hi = 1'b0; step();
    chk(lvl, 1'b0, "R7 start level follows field");
    byp = 1'b0; en = 1'b1;

    // sync-ignore static level
    nosync = 1'b1; force_hi = 1'b1; sync = 1'b1;
    step(); chk(lvl, 1'b1, "R8 forced high");
    sync = 1'b0; step(); chk(lvl, 1'b1, "R8 sync release no effect");
    sync = 1'b1; step(); chk(lvl, 1'b1, "R8 sync no effect");
    force_hi = 1'b0; step(); chk(lvl, 1'b0, "R8 forced low");
    chk(div_clk, 1'b0, "R9 div_clk follows static lvl");
    en = 1'b0; force_hi = 1'b1; step();
    chk(lvl, 1'b1, "R8 forced high again");
    chk(div_clk, 1'b0, "R9 gated by en");
    nosync = 1'b0; sync = 1'b0; en = 1'b1;
    step(); step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule